// File: doc/BRIEF.md
# Two-Channel Match Timer

This block holds two independent 32-bit event channels behind a small memory-mapped register bus. Each channel has a control register, an up-counter and a match register. Software stops a channel, loads its counter (normally with zero) and its match value, then starts it. While a channel runs, its counter advances by one on every clock. When the counter reaches the match value, the channel's status bit is set. An interrupt line for that channel then follows the status bit, gated by the channel's interrupt enable.

Status bits are cleared by writing ones to them. The counter keeps running past the match value and wraps through zero, so a second event comes only when the counter reaches the match value again. A one-bit watchdog-enable register is plain read/write storage with no effect on the rest of the block. There is no prescaler: counting is always at the full clock rate.

Top module: `mtimer`

## Requirements
- R1: After synchronous reset, every control, match, counter, status and watchdog-enable register reads 0, and both interrupt outputs are 0.
- R2: Register map. Channel n has its control register at 0x00+4n, its match register at 0x18+4n and its counter at 0x48+4n. Status is at 0x60 and watchdog-enable at 0x64. In control, bit 0 enables counting, bit 1 enables the interrupt, bit 2 is stored without effect, and higher bits read 0. A read returns its data on the read-data port after the first rising edge following the request. Unmapped addresses read 0 and ignore writes.
- R3: While control bit 0 is 1, the counter increases by exactly one per clock. While it is 0, the counter holds its value.
- R4: A write to a counter register loads the written value at once. The write takes precedence over the increment, even while the channel is counting.
- R5: When a counting channel's counter equals its match value, status bit n is set at the next edge. With the counter loaded to zero and a match of 2 (the smallest supported distance), the channel's interrupt output rises 4 clocks after the edge that starts the channel.
- R6: A channel whose control bit 0 is 0 never sets its status bit, even when its counter equals its match value.
- R7: Interrupt output n equals the registered AND of status bit n and control bit 1, one clock behind both. Clearing control bit 1 drops the output without clearing the status bit.
- R8: Writing status clears each bit written as 1 and leaves each bit written as 0. Writing 0xFFFF clears every pending bit.
- R9: The counter wraps from 0xFFFFFFFF to 0 and keeps counting after a match. The channel raises no further event until the counter equals the match value again.
- R10: The two channels count, match and interrupt independently. Activity on one channel leaves the other channel's counter, status bit and interrupt output unchanged.
- R11: Bit 0 of the watchdog-enable register is stored and reads back. It affects nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 = write request, 0 = read request |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| irq | output | NCH (2) | Per-channel interrupt outputs |

## Verification
Match timing is exercised with three distinct patterns:
- the minimum distance of 2 from a zeroed counter;
- a distance of 3 that crosses the 32-bit wrap point;
- a distance of 6 on the second channel while the first channel sits idle.

Each interrupt arrives after an exact cycle count. These counts separate an off-by-one in the compare, the status register or the interrupt register from a wrong wrap. A channel that is stopped with its counter equal to its match separates gating by the count enable from gating by the interrupt enable. Status writes of 0, a single bit and 0xFFFF tell per-bit write-one-to-clear apart from a plain store or a clear-all.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  // register offsets (byte addresses)
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_MATCH = 'h18;
  localparam int unsigned OFS_COUNT = 'h48;
  localparam int unsigned OFS_STAT  = 'h60;
  localparam int unsigned OFS_WDOG  = 'h64;
  localparam int unsigned CH_STRIDE = 4;

  // control register layout
  localparam int unsigned CTRL_W = 3;
  localparam int unsigned CB_RUN = 0;
  localparam int unsigned CB_IRQ = 1;
endpackage

// File: rtl/mt_regdec.sv
module mt_regdec
  import mtimer_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned CW  = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [AW-1:0]                  bus_addr,
  output logic [NCH-1:0]                 wr_ctrl,
  output logic [NCH-1:0]                 wr_match,
  output logic [NCH-1:0]                 wr_count,
  output logic                           wr_stat,
  output logic                           wr_wdog,
  input  logic [NCH-1:0][CTRL_W-1:0]     ctrl_all,
  input  logic [NCH-1:0][CW-1:0]         match_all,
  input  logic [NCH-1:0][CW-1:0]         count_all,
  input  logic [NCH-1:0]                 stat_all,
  input  logic                           wdog_q,
  output logic [DW-1:0]                  rdata
);

  logic          wr_req;
  logic          rd_req;
  logic [DW-1:0] rd_next;

  assign wr_req = bus_sel & bus_wr;
  assign rd_req = bus_sel & ~bus_wr;

  // per-channel write strobes
  for (genvar g = 0; g < NCH; g++) begin : g_dec
    localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL  + CH_STRIDE * g);
    localparam logic [AW-1:0] A_MATCH = AW'(OFS_MATCH + CH_STRIDE * g);
    localparam logic [AW-1:0] A_COUNT = AW'(OFS_COUNT + CH_STRIDE * g);
    assign wr_ctrl[g]  = wr_req && (bus_addr == A_CTRL);
    assign wr_match[g] = wr_req && (bus_addr == A_MATCH);
    assign wr_count[g] = wr_req && (bus_addr == A_COUNT);
  end

  assign wr_stat = wr_req && (bus_addr == AW'(OFS_STAT));
  assign wr_wdog = wr_req && (bus_addr == AW'(OFS_WDOG));

  // read multiplexer; unmapped addresses give zero
  always_comb begin
    rd_next = '0;
    for (int unsigned i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(OFS_CTRL + CH_STRIDE * i))  rd_next = DW'(ctrl_all[i]);
      if (bus_addr == AW'(OFS_MATCH + CH_STRIDE * i)) rd_next = DW'(match_all[i]);
      if (bus_addr == AW'(OFS_COUNT + CH_STRIDE * i)) rd_next = DW'(count_all[i]);
    end
    if (bus_addr == AW'(OFS_STAT)) rd_next = DW'(stat_all);
    if (bus_addr == AW'(OFS_WDOG)) rd_next = DW'(wdog_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_req) rdata <= rd_next;
  end

  // R2: a write request hits at most one register
  a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_ctrl, wr_match, wr_count, wr_stat, wr_wdog}));

  // R2: read data only changes in the cycle after a read request
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(rdata));

endmodule

// File: rtl/mt_channel.sv
module mt_channel
  import mtimer_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_match,
  input  logic              wr_count,
  input  logic [CTRL_W-1:0] ctrl_wd,
  input  logic [CW-1:0]     val_wd,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CW-1:0]     match_q,
  output logic [CW-1:0]     count_q,
  output logic              hit,
  output logic              ie
);

  logic run;

  assign run = ctrl_q[CB_RUN];
  assign ie  = ctrl_q[CB_IRQ];

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_wd;
  end

  always_ff @(posedge clk) begin
    if (rst)           match_q <= '0;
    else if (wr_match) match_q <= val_wd;
  end

  // software load wins over the increment; natural wrap at 2^CW
  always_ff @(posedge clk) begin
    if (rst)           count_q <= '0;
    else if (wr_count) count_q <= val_wd;
    else if (run)      count_q <= count_q + 1'b1;
  end

  // counter moves every running cycle, so equality lasts one cycle
  assign hit = run && (count_q == match_q);

  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    run && !wr_count |=> count_q == $past(count_q) + 1'b1);

  a_r3_count_hold: assert property (@(posedge clk) disable iff (rst)
    !run && !wr_count |=> $stable(count_q));

  a_r4_load_wins: assert property (@(posedge clk) disable iff (rst)
    wr_count |=> count_q == $past(val_wd));

endmodule

// File: rtl/mt_irq.sv
module mt_irq #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] ie,
  input  logic [NCH-1:0] clr_req,
  output logic [NCH-1:0] stat_q,
  output logic [NCH-1:0] irq_q
);

  logic [NCH-1:0] stat_d;

  // a new event in the same cycle as a clear keeps the bit set
  assign stat_d = (stat_q & ~clr_req) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= '0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= stat_q & ie;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r5_event_sets: assert property (@(posedge clk) disable iff (rst)
      hit[g] |=> stat_q[g]);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      stat_q[g] && !clr_req[g] |=> stat_q[g]);

    a_r8_clears: assert property (@(posedge clk) disable iff (rst)
      clr_req[g] && !hit[g] |=> !stat_q[g]);

    a_r7_masked: assert property (@(posedge clk) disable iff (rst)
      !ie[g] |=> !irq_q[g]);

    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
      !stat_q[g] && !hit[g] |=> !stat_q[g]);
  end

endmodule

// File: rtl/mtimer.sv
module mtimer
  import mtimer_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned CW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq
);

  logic [NCH-1:0]             wr_ctrl;
  logic [NCH-1:0]             wr_match;
  logic [NCH-1:0]             wr_count;
  logic                       wr_stat;
  logic                       wr_wdog;
  logic [NCH-1:0][CTRL_W-1:0] ctrl_all;
  logic [NCH-1:0][CW-1:0]     match_all;
  logic [NCH-1:0][CW-1:0]     count_all;
  logic [NCH-1:0]             hit;
  logic [NCH-1:0]             ie;
  logic [NCH-1:0]             stat_all;
  logic [NCH-1:0]             clr_req;
  logic                       wdog_q;

  mt_regdec #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wr_ctrl   (wr_ctrl),
    .wr_match  (wr_match),
    .wr_count  (wr_count),
    .wr_stat   (wr_stat),
    .wr_wdog   (wr_wdog),
    .ctrl_all  (ctrl_all),
    .match_all (match_all),
    .count_all (count_all),
    .stat_all  (stat_all),
    .wdog_q    (wdog_q),
    .rdata     (bus_rdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mt_channel #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_ctrl  (wr_ctrl[g]),
      .wr_match (wr_match[g]),
      .wr_count (wr_count[g]),
      .ctrl_wd  (bus_wdata[CTRL_W-1:0]),
      .val_wd   (bus_wdata[CW-1:0]),
      .ctrl_q   (ctrl_all[g]),
      .match_q  (match_all[g]),
      .count_q  (count_all[g]),
      .hit      (hit[g]),
      .ie       (ie[g])
    );
  end

  assign clr_req = wr_stat ? bus_wdata[NCH-1:0] : '0;

  mt_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .ie      (ie),
    .clr_req (clr_req),
    .stat_q  (stat_all),
    .irq_q   (irq)
  );

  // watchdog-enable: storage only
  always_ff @(posedge clk) begin
    if (rst)          wdog_q <= 1'b0;
    else if (wr_wdog) wdog_q <= bus_wdata[0];
  end

  // R11: the stored bit changes only on its own write
  a_r11_wdog_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr && bus_addr == AW'(OFS_WDOG)) |=> $stable(wdog_q));

endmodule

// File: tb/mtimer_tb_top.sv
`timescale 1ns/1ps
module mtimer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mtimer dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int ch, input int maxc, output int k);
    k = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (irq[ch] && k == 0) k = i;
      if (k != 0) break;
    end
  endtask

  task automatic cleanup();
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h60, 32'hFFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [7:0] addrs [8] = '{8'h00, 8'h04, 8'h18, 8'h1C, 8'h48, 8'h4C, 8'h60, 8'h64};
    for (int i = 0; i < 8; i++) begin
      rd(addrs[i], d);
      chk($sformatf("R1 reset reg 0x%02h", addrs[i]), d, 0);
    end
    chk("R1 reset irq", {30'd0, irq}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFFD); rd(8'h04, d); chk("R2 ctrl1 bits[2:0]", d, 5);
    wr(8'h1C, 32'hA5A5_1234); rd(8'h1C, d); chk("R2 match1 readback", d, 32'hA5A5_1234);
    wr(8'h08, 32'hDEAD_BEEF); rd(8'h08, d); chk("R2 unmapped reads 0", d, 0);
    rd(8'h04, d); chk("R2 unmapped write ignored", d, 5);
    wr(8'h04, 0); wr(8'h1C, 0);
    cleanup();
  endtask

  task automatic t_wdog();
    logic [31:0] d;
    wr(8'h64, 1); rd(8'h64, d); chk("R11 wdog set", d, 1);
    rd(8'h00, d); chk("R11 wdog no effect on ctrl0", d, 0);
    wr(8'h64, 32'hFFFF_FFFE); rd(8'h64, d); chk("R11 wdog clear", d, 0);
  endtask

  task automatic t_count();
    logic [31:0] a, b;
    wr(8'h48, 0); wr(8'h00, 1);
    rd(8'h48, a); rd(8'h48, b); chk("R3 step of one", b - a, 1);
    wr(8'h48, 32'h100); rd(8'h48, a); chk("R4 load while counting", a, 32'h100);
    wr(8'h00, 0);
    rd(8'h48, a); rd(8'h48, b); chk("R3 hold when stopped", b - a, 0);
    cleanup();
  endtask

  task automatic t_match_min();
    logic [31:0] d; int k;
    wr(8'h48, 0); wr(8'h18, 2); wr(8'h00, 3);
    wait_irq(0, 20, k); chk("R5 irq delay for match 2", k, 4);
    rd(8'h60, d); chk("R5 status bit0", d, 1);
    cleanup();
  endtask

  task automatic t_disabled();
    logic [31:0] d; int seen;
    wr(8'h48, 5); wr(8'h18, 5); wr(8'h00, 2);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (irq[0]) seen = 1;
    end
    chk("R6 no irq while stopped", seen, 0);
    rd(8'h60, d); chk("R6 no status while stopped", d, 0);
    rd(8'h48, d); chk("R3 counter held at 5", d, 5);
    cleanup();
  endtask

  task automatic t_irq_mask();
    logic [31:0] d; int k;
    wr(8'h48, 0); wr(8'h18, 3); wr(8'h00, 3);
    wait_irq(0, 20, k); chk("R7 irq delay for match 3", k, 5);
    wr(8'h00, 1);
    @(negedge clk); chk("R7 irq drops when masked", {31'd0, irq[0]}, 0);
    rd(8'h60, d); chk("R7 status kept while masked", d, 1);
    wr(8'h00, 3);
    @(negedge clk); chk("R7 irq returns when unmasked", {31'd0, irq[0]}, 1);
    cleanup();
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(8'h48, 0); wr(8'h18, 2); wr(8'h00, 1);
    wr(8'h4C, 0); wr(8'h1C, 2); wr(8'h04, 1);
    repeat (6) @(negedge clk);
    wr(8'h00, 0); wr(8'h04, 0);
    rd(8'h60, d); chk("R8 both pending", d, 3);
    wr(8'h60, 0); rd(8'h60, d); chk("R8 write 0 keeps bits", d, 3);
    wr(8'h60, 2); rd(8'h60, d); chk("R8 clear bit1 only", d, 1);
    wr(8'h4C, 0); wr(8'h04, 1);
    repeat (6) @(negedge clk);
    wr(8'h04, 0);
    rd(8'h60, d); chk("R8 both pending again", d, 3);
    wr(8'h60, 32'hFFFF); rd(8'h60, d); chk("R8 0xFFFF clears all", d, 0);
    cleanup();
  endtask

  task automatic t_wrap();
    logic [31:0] d; int k, seen;
    wr(8'h48, 32'hFFFF_FFFE); wr(8'h18, 1); wr(8'h00, 3);
    wait_irq(0, 20, k); chk("R9 event across wrap", k, 5);
    wr(8'h60, 1);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq[0]) seen = 1;
    end
    chk("R9 no repeat after match", seen, 0);
    rd(8'h60, d); chk("R9 status stays clear", d, 0);
    cleanup();
  endtask

  task automatic t_independent();
    logic [31:0] d; int k, seen0;
    wr(8'h48, 32'h55); wr(8'h4C, 0); wr(8'h1C, 6); wr(8'h04, 3);
    k = 0; seen0 = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (irq[0]) seen0 = 1;
      if (irq[1]) begin k = i; break; end
    end
    chk("R10 ch1 irq delay for match 6", k, 8);
    chk("R10 ch0 irq untouched", seen0, 0);
    rd(8'h60, d); chk("R10 only status bit1", d, 2);
    rd(8'h48, d); chk("R10 ch0 counter unchanged", d, 32'h55);
    cleanup();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_wdog();
    t_count();
    t_match_min();
    t_disabled();
    t_irq_mask();
    t_w1c();
    t_wrap();
    t_independent();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule